// File: doc/BRIEF.md
# In-band Xon/Xoff flow controller

This block adds character-based flow control to a UART. It sits next to the receiver and the transmitter. The framing logic and the FIFOs live outside it. On the receive path it watches each received character for the programmed stop and start codes. A stop code makes the local transmitter pause after its current character. A start code lets the transmitter run again. Matched codes are removed from the stream instead of being written to the receive FIFO. A received stop code also sets a sticky interrupt flag for the host.

On the transmit path it watches the receive FIFO fill level. When the level climbs above the halt threshold, it asks the transmitter to send the stop code. When the level later drops to the resume threshold or below, it asks for the start code. Each direction can use a single code or a two-character code. There are four 8-bit code registers: two start codes and two stop codes.

The transmitter is expected to check the inject request before it starts each new data character. Injected codes therefore go ahead of queued data but never break into a character that is already being shifted out.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: With `mode[2]`=1 (receive flow enabled) and `mode[3]`=0 (single-code receive), a character equal to `xoff1` or `xon1` is not written (`fifo_wr` low in its cycle). Any other character is written in the same cycle it arrives.
- R2: With `mode[3:2]`=2'b11 (two-code receive), a character equal to `xon1` or `xoff1` is withheld. If the next character completes the pair (`xoff1`,`xoff2`) or (`xon1`,`xon2`), neither character is written. Otherwise the withheld character is written in the arrival cycle of the next character. That next character is then either withheld itself (if it matches a first code) or written one cycle later. Received characters are at least two cycles apart.
- R3: A received stop code raises `tx_hold` after the arrival edge. A received start code lowers it. Clearing `mode[2]` lowers it.
- R4: A received stop code sets `xoff_irq`. `irq_clr` clears it. A stop code arriving in the same cycle as `irq_clr` leaves the flag set.
- R5: With `mode[0]`=1 (transmit flow enabled), a stop code is requested once the level exceeds `halt_lvl`. It is requested only once until a start code has been sent.
- R6: A start code is requested only after a stop code has been sent, and only when the level is at or below `resume_lvl`.
- R7: With `mode[1]`=1 (two-code transmit), `xoff1` then `xoff2` (or `xon1` then `xon2`) are requested. Otherwise only `xoff1` (or `xon1`) is requested. `inj_req` and `inj_char` stay unchanged until `inj_ack`.
- R8: With `mode[2]`=0, every character is written and no code has any effect. With `mode[0]`=0, no code is requested.
- R9: After reset, `fifo_wr`, `inj_req`, `tx_hold` and `xoff_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | [0] tx enable, [1] tx two-code, [2] rx enable, [3] rx two-code |
| xon1 | input | 8 | First start code |
| xon2 | input | 8 | Second start code |
| xoff1 | input | 8 | First stop code |
| xoff2 | input | 8 | Second stop code |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | 8 | Character to write |
| rx_level | input | LVL_W | Receive FIFO fill level |
| halt_lvl | input | LVL_W | Level above which a stop code is sent |
| resume_lvl | input | LVL_W | Level at or below which a start code is sent |
| inj_req | output | 1 | Request to send a flow character next |
| inj_char | output | 8 | Flow character to send |
| inj_ack | input | 1 | Transmitter took the flow character |
| tx_hold | output | 1 | Transmitter must not start new data |
| xoff_irq | output | 1 | Sticky stop-code-received flag |
| irq_clr | input | 1 | Clears `xoff_irq` |

## Verification
A received stop code and an `irq_clr` pulse can fall in the same cycle. Set and clear then compete for `xoff_irq`. The bench drives both on one edge and expects the flag to stay high. A second collision happens in two-code receive mode. A mismatching second character flushes the withheld one and may itself become withheld, all in the same cycle. Random streams drawn heavily from the four codes provoke this case. The bench judges it by comparing the written-character sequence against a model of the requirements.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode,
  input  logic [7:0]       xon1,
  input  logic [7:0]       xon2,
  input  logic [7:0]       xoff1,
  input  logic [7:0]       xoff2,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             inj_req,
  output logic [7:0]       inj_char,
  input  logic             inj_ack,
  output logic             tx_hold,
  output logic             xoff_irq,
  input  logic             irq_clr
);
  typedef enum logic [1:0] {TX_IDLE, TX_FIRST, TX_SECOND} tx_st_t;

  wire tx_en  = mode[0];
  wire tx_dbl = mode[1];
  wire rx_en  = mode[2];
  wire rx_dbl = mode[3];

  logic       held_v, held_on, held_off, pend_v;
  logic [7:0] held_d, pend_d;

  wire c_on1  = rx_char == xon1;
  wire c_off1 = rx_char == xoff1;
  wire pair_off = rx_en && rx_dbl && held_v && held_off && rx_char == xoff2;
  wire pair_on  = rx_en && rx_dbl && held_v && held_on && rx_char == xon2 && !pair_off;
  wire got_off  = rx_valid && rx_en && (rx_dbl ? pair_off : c_off1);
  wire got_on   = rx_valid && rx_en && !got_off && (rx_dbl ? pair_on : c_on1);
  wire start_hold = rx_valid && rx_en && rx_dbl && !pair_off && !pair_on && (c_on1 || c_off1);
  wire flush    = rx_valid && held_v && !pair_off && !pair_on;

  assign fifo_wr   = pend_v || (rx_valid && (flush || !(got_off || got_on || start_hold)));
  assign fifo_data = pend_v ? pend_d : (flush ? held_d : rx_char);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v   <= 1'b0;
      held_on  <= 1'b0;
      held_off <= 1'b0;
      held_d   <= '0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
    end else begin
      pend_v <= flush && !start_hold;
      if (rx_valid) begin
        pend_d   <= rx_char;
        held_v   <= start_hold;
        held_on  <= c_on1;
        held_off <= c_off1;
        held_d   <= rx_char;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= 1'b0;
      xoff_irq <= 1'b0;
    end else begin
      if (!rx_en)       tx_hold <= 1'b0;
      else if (got_off) tx_hold <= 1'b1;
      else if (got_on)  tx_hold <= 1'b0;
      if (got_off)      xoff_irq <= 1'b1;
      else if (irq_clr) xoff_irq <= 1'b0;
    end
  end

  tx_st_t st;
  logic   sent_off, kind_off;

  wire need_off = tx_en && !sent_off && rx_level > halt_lvl;
  wire need_on  = tx_en && sent_off && rx_level <= resume_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      sent_off <= 1'b0;
      kind_off <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (!tx_en) sent_off <= 1'b0;
          else if (need_off || need_on) begin
            kind_off <= need_off;
            st       <= TX_FIRST;
          end
        end
        TX_FIRST: if (inj_ack) begin
          if (tx_dbl) st <= TX_SECOND;
          else begin
            st       <= TX_IDLE;
            sent_off <= kind_off;
          end
        end
        default: if (inj_ack) begin
          st       <= TX_IDLE;
          sent_off <= kind_off;
        end
      endcase
    end
  end

  assign inj_req  = st != TX_IDLE;
  assign inj_char = kind_off ? ((st == TX_SECOND) ? xoff2 : xoff1)
                             : ((st == TX_SECOND) ? xon2  : xon1);
endmodule

// File: rtl/xonxoff_flow_ctl_chk.sv
module xonxoff_flow_ctl_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode,
  input logic [7:0]       xon1,
  input logic [7:0]       xoff1,
  input logic             rx_valid,
  input logic [7:0]       rx_char,
  input logic             fifo_wr,
  input logic             inj_req,
  input logic [7:0]       inj_char,
  input logic             inj_ack,
  input logic             tx_hold,
  input logic             xoff_irq
);
  // R7
  inj_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_req && !inj_ack |=> inj_req && $stable(inj_char));
  // R3
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> $past(rx_valid && mode[2]));
  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_irq) |-> $past(rx_valid && mode[2]));
  // R1
  single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode[3:2] == 2'b01 && (rx_char == xoff1 || rx_char == xon1) && !$past(rx_valid))
      |-> !fifo_wr);
  // R8
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] && !inj_req |=> !inj_req);
  // R2
  rx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind xonxoff_flow_ctl xonxoff_flow_ctl_chk #(.LVL_W(LVL_W)) chk_i (.*);

// File: tb/xonxoff_flow_ctl_tb_top.sv
module xonxoff_flow_ctl_tb_top;
  localparam int LW = 7;
  logic clk = 0, rst_n = 0;
  logic [3:0] mode = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h22, xoff1 = 8'h13, xoff2 = 8'h33;
  logic rx_valid = 0, inj_ack = 0, irq_clr = 0;
  logic [7:0] rx_char = 0;
  logic [LW-1:0] rx_level = 0, halt_lvl = 40, resume_lvl = 10;
  logic fifo_wr, inj_req, tx_hold, xoff_irq;
  logic [7:0] fifo_data, inj_char;
  int total = 0, bad = 0;
  bit done = 0, ack_rand = 0;
  logic [7:0] got_q[$], exp_q[$], tgot_q[$], texp_q[$];
  bit m_held, m_hon, m_hoff, m_hold, m_irq, m_sent;
  logic [7:0] m_hd;

  always #2 clk = ~clk;

  xonxoff_flow_ctl #(.LVL_W(LW)) dut_i (.*);

  always @(posedge clk) begin
    if (fifo_wr) got_q.push_back(fifo_data);
    if (inj_req && inj_ack) tgot_q.push_back(inj_char);
  end

  always @(negedge clk) inj_ack <= inj_req && (ack_rand ? ($urandom % 3 == 0) : 1'b1);

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_q(string req, bit tx);
    logic [7:0] g[$], e[$];
    bit ok;
    g = tx ? tgot_q : got_q;
    e = tx ? texp_q : exp_q;
    ok = g.size() == e.size();
    for (int i = 0; ok && i < g.size(); i++) if (g[i] != e[i]) ok = 0;
    chk(ok, req, g.size() ? int'(g[g.size()-1]) : -1, e.size() ? int'(e[e.size()-1]) : -1);
    if (tx) begin tgot_q.delete(); texp_q.delete(); end
    else begin got_q.delete(); exp_q.delete(); end
  endtask

  function automatic void model_rx(logic [7:0] c);
    if (!mode[2]) exp_q.push_back(c);
    else if (!mode[3]) begin
      if (c == xoff1) begin m_hold = 1; m_irq = 1; end
      else if (c == xon1) m_hold = 0;
      else exp_q.push_back(c);
    end else begin
      if (m_held && m_hoff && c == xoff2) begin m_hold = 1; m_irq = 1; m_held = 0; end
      else if (m_held && m_hon && c == xon2) begin m_hold = 0; m_held = 0; end
      else begin
        if (m_held) exp_q.push_back(m_hd);
        m_held = (c == xon1 || c == xoff1);
        m_hon = c == xon1; m_hoff = c == xoff1; m_hd = c;
        if (!m_held) exp_q.push_back(c);
      end
    end
  endfunction

  task automatic send_rx(logic [7:0] c, string req);
    @(negedge clk); rx_valid = 1; rx_char = c; model_rx(c);
    @(negedge clk); rx_valid = 0;
    repeat (2) @(negedge clk);
    cmp_q({req, " rx stream"}, 0);
    chk(tx_hold == m_hold, {req, " hold"}, tx_hold, m_hold);
    chk(xoff_irq == m_irq, {req, " irq"}, xoff_irq, m_irq);
  endtask

  task automatic set_level(int l, string req);
    @(negedge clk); rx_level = LW'(l);
    if (mode[0] && !m_sent && l > halt_lvl) begin
      texp_q.push_back(xoff1); if (mode[1]) texp_q.push_back(xoff2); m_sent = 1;
    end else if (mode[0] && m_sent && l <= resume_lvl) begin
      texp_q.push_back(xon1); if (mode[1]) texp_q.push_back(xon2); m_sent = 0;
    end
    repeat (3) @(negedge clk);
    while (inj_req) @(negedge clk);
    @(negedge clk);
    cmp_q(req, 1);
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 6)
      0: return xon1; 1: return xon2; 2: return xoff1; 3: return xoff2;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R9
    chk(!fifo_wr && !inj_req && !tx_hold && !xoff_irq, "R9 reset",
        {fifo_wr, inj_req, tx_hold, xoff_irq}, 0);
    rst_n = 1;
    mode = 4'b0100;
    // R1 same-cycle write / drop
    @(negedge clk); rx_valid = 1; rx_char = 8'h41; #1;
    chk(fifo_wr && fifo_data == 8'h41, "R1 plain same cycle", fifo_data, 8'h41);
    @(negedge clk); rx_valid = 0; got_q.delete();
    @(negedge clk); rx_valid = 1; rx_char = xoff1; #1;
    chk(!fifo_wr, "R1 xoff dropped", fifo_wr, 0);
    @(negedge clk); rx_valid = 0; got_q.delete();
    // R3 hold after the edge
    chk(tx_hold, "R3 hold set", tx_hold, 1);
    m_hold = 1; m_irq = 1;
    send_rx(xon1, "R3 xon release");
    // R4 simultaneous set and clear
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; m_irq = 0;
    chk(!xoff_irq, "R4 cleared", xoff_irq, 0);
    @(negedge clk); rx_valid = 1; rx_char = xoff1; irq_clr = 1; model_rx(xoff1);
    @(negedge clk); rx_valid = 0; irq_clr = 0;
    chk(xoff_irq, "R4 set wins", xoff_irq, 1);
    for (int i = 0; i < 150; i++) begin
      if (i % 40 == 39) begin @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; m_irq = 0; end
      send_rx(pick(), "R1 random");
    end
    // R2 two-code receive
    mode = 4'b1100;
    send_rx(xoff1, "R2 first withheld");
    send_rx(xoff2, "R2 pair done");
    send_rx(xon1, "R2 withheld");
    send_rx(8'h55, "R2 mismatch flush");
    send_rx(xoff1, "R2 withheld again");
    send_rx(xon1, "R2 mismatch rehold");
    send_rx(xon2, "R2 xon pair");
    for (int i = 0; i < 300; i++) send_rx(pick(), "R2 random");
    send_rx(8'h41, "R2 drain");
    // R8 receive disabled
    mode = 4'b0000; m_hold = 0;
    send_rx(xoff1, "R8 rx off passes");
    send_rx(xon2, "R8 rx off passes");
    // R5 R6 transmit single
    mode = 4'b0001; m_sent = 0;
    set_level(5, "R6 no xon before xoff");
    set_level(41, "R5 xoff on halt");
    set_level(60, "R5 once per episode");
    set_level(20, "R6 above resume");
    set_level(10, "R6 xon at resume");
    // R7 two-code transmit with slow ack
    mode = 4'b0011; ack_rand = 1;
    set_level(41, "R7 xoff pair");
    set_level(3, "R7 xon pair");
    for (int i = 0; i < 120; i++) set_level($urandom % 64, "R7 random levels");
    // R8 transmit disabled
    mode = 4'b0000; m_sent = 0;
    set_level(70, "R8 tx off");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule